// File: doc/BRIEF.md
# Two-Port Semaphore Latch Bank

This block provides eight hardware semaphore latches shared by two independent ports, called left and right. A semaphore is a single token that at most one side owns at a time. Software on either side claims a token by writing a zero to it, gives it back or withdraws a claim by writing a one, and reads the token back to learn whether it now owns it. A read returns zero on every data line when the reading side owns the token and one on every data line when it does not.

Each latch keeps a standing request bit for each side. A request made while the other side holds the token is remembered, and ownership moves to the waiting side in the same clock edge that records the holder's release. There is no window in which a third party could take the token. If both sides claim a free token in the same cycle, the left side wins. The right side's claim stays pending and takes effect when the left side releases.

A port reaches the latches only when its semaphore select is high and its memory enable is low. Read data is captured in an output register on the clock edge that ends the read cycle. It stays unchanged until the same port reads again, whatever the other port does to the token in the meantime.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free and no request is pending. Both read-data buses show all ones before any read.
- R2: The semaphore index is taken from address bits 2:0 only. Address bits above bit 2 have no effect on which latch is accessed.
- R3: A side that writes a zero (a request) to a free semaphore owns it. That side then reads all zeros at that index, the other side reads all ones, and the two sides never both own a latch.
- R4: A write looks only at data bit 0, where 0 is a request and 1 is a release or cancel. All other data bits are ignored.
- R5: When the owner writes a one and the other side has no pending request, the semaphore becomes free and both sides read all ones.
- R6: A request from the non-owning side is held as pending. The requester becomes owner on the clock edge that records the holder's release.
- R7: A non-owning side that writes a one only withdraws its own pending request. After that, a release by the owner leaves the semaphore free.
- R8: If both sides request the same free semaphore in the same cycle, the left side becomes the owner and the right side's request stays pending.
- R9: A read cycle (select high, memory enable low, read high, write low) loads the read-data register one clock later with the side's token view on all data lines. The register then holds that value until the next read by the same side.
- R10: A write with select low, or with memory enable high, changes no semaphore.
- R11: The eight semaphores are independent. Claiming one semaphore leaves the others free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel | input | 1 | Left semaphore select, active high |
| l_mem_en | input | 1 | Left memory enable; while it is high, semaphore access is blocked |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_addr | input | ADDR_W | Left address; bits 2:0 pick the semaphore |
| l_wdata | input | DATA_W | Left write data; only bit 0 is used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel | input | 1 | Right semaphore select, active high |
| r_mem_en | input | 1 | Right memory enable; while it is high, semaphore access is blocked |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_addr | input | ADDR_W | Right address; bits 2:0 pick the semaphore |
| r_wdata | input | DATA_W | Right write data; only bit 0 is used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
A corrupt request bit or holder bit is invisible until some side reads that index. It then appears one clock after the read cycle as a wrong all-zero or all-one word. Often only one side shows it, for example a lost pending request that surfaces only after the holder releases. The bench therefore reads both sides after every state change on all eight indices, with varying upper address bits and data patterns. A fault in the output register, such as data that follows the token instead of holding, shows only when the token changes between two reads. A dedicated sequence covers that case.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int SEM_N     = 8;
  localparam int SEM_IDX_W = $clog2(SEM_N);

  typedef struct packed {
    logic                 wr_go;
    logic                 wr_bit;
    logic                 rd_go;
    logic [SEM_IDX_W-1:0] idx;
  } sem_cmd_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
  import sem_pkg::*;
(
  input  logic                 sel,
  input  logic                 mem_en,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [SEM_IDX_W-1:0] idx,
  input  logic                 wbit,
  output sem_cmd_t             cmd
);
  logic access;

  always_comb begin
    access     = sel & ~mem_en;
    cmd.wr_go  = access & wr;
    cmd.rd_go  = access & rd & ~wr;
    cmd.wr_bit = wbit;
    cmd.idx    = idx;
  end
endmodule

// File: rtl/sem_cell.sv
module sem_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic l_go,
  input  logic l_bit,
  input  logic r_go,
  input  logic r_bit,
  output logic own_l,
  output logic own_r
);
  logic req_l_q, req_r_q, hold_r_q;
  logic req_l_d, req_r_d, hold_r_d;
  logic upd;

  always_comb begin
    upd     = l_go | r_go;
    req_l_d = l_go ? ~l_bit : req_l_q;
    req_r_d = r_go ? ~r_bit : req_r_q;
    if (req_l_d && req_r_d) begin
      if (req_l_q && req_r_q) hold_r_d = hold_r_q;
      else if (req_l_q)       hold_r_d = 1'b0;
      else if (req_r_q)       hold_r_d = 1'b1;
      else                    hold_r_d = 1'b0;
    end else begin
      hold_r_d = req_r_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_l_q  <= 1'b0;
      req_r_q  <= 1'b0;
      hold_r_q <= 1'b0;
    end else if (upd) begin
      req_l_q  <= req_l_d;
      req_r_q  <= req_r_d;
      hold_r_q <= hold_r_d;
    end
  end

  assign own_l = req_l_q & (~req_r_q | ~hold_r_q);
  assign own_r = req_r_q & (~req_l_q |  hold_r_q);
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg
  import sem_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  logic [SEM_IDX_W-1:0] idx,
  input  logic [SEM_N-1:0]  own,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;

  always_comb rdata_d = {DATA_W{~own[idx]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '1;
    else if (rd_go) rdata <= rdata_d;
  end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  sem_cmd_t         l_cmd, r_cmd;
  logic [SEM_N-1:0] own_l, own_r;
  logic             unused_bits;

  assign unused_bits = ^{l_addr[ADDR_W-1:SEM_IDX_W], r_addr[ADDR_W-1:SEM_IDX_W],
                         l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

  sem_port_decode u_dec_l (
    .sel(l_sel), .mem_en(l_mem_en), .wr(l_wr), .rd(l_rd),
    .idx(l_addr[SEM_IDX_W-1:0]), .wbit(l_wdata[0]), .cmd(l_cmd)
  );

  sem_port_decode u_dec_r (
    .sel(r_sel), .mem_en(r_mem_en), .wr(r_wr), .rd(r_rd),
    .idx(r_addr[SEM_IDX_W-1:0]), .wbit(r_wdata[0]), .cmd(r_cmd)
  );

  for (genvar i = 0; i < SEM_N; i++) begin : g_cell
    logic l_hit, r_hit;
    assign l_hit = l_cmd.wr_go & (l_cmd.idx == SEM_IDX_W'(i));
    assign r_hit = r_cmd.wr_go & (r_cmd.idx == SEM_IDX_W'(i));
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_go(l_hit), .l_bit(l_cmd.wr_bit),
      .r_go(r_hit), .r_bit(r_cmd.wr_bit),
      .own_l(own_l[i]), .own_r(own_r[i])
    );
  end

  sem_read_reg #(.DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd_go(l_cmd.rd_go), .idx(l_cmd.idx),
    .own(own_l), .rdata(l_rdata)
  );

  sem_read_reg #(.DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd_go(r_cmd.rd_go), .idx(r_cmd.idx),
    .own(own_r), .rdata(r_rdata)
  );
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_sel,
  input logic              l_mem_en,
  input logic              l_wr,
  input logic              l_rd,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              r_sel,
  input logic              r_mem_en,
  input logic              r_wr,
  input logic              r_rd,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic [SEM_N-1:0]  own_l,
  input logic [SEM_N-1:0]  own_r
);
  logic                 l_wgo, r_wgo, l_rgo, r_rgo, tie_req;
  logic [SEM_IDX_W-1:0] l_idx, r_idx;
  logic                 l_view, r_view;

  always_comb begin
    l_idx   = l_addr[SEM_IDX_W-1:0];
    r_idx   = r_addr[SEM_IDX_W-1:0];
    l_wgo   = l_sel & ~l_mem_en & l_wr;
    r_wgo   = r_sel & ~r_mem_en & r_wr;
    l_rgo   = l_sel & ~l_mem_en & l_rd & ~l_wr;
    r_rgo   = r_sel & ~r_mem_en & r_rd & ~r_wr;
    l_view  = ~own_l[l_idx];
    r_view  = ~own_r[r_idx];
    tie_req = l_wgo & r_wgo & ~l_wdata[0] & ~r_wdata[0] & (l_idx == r_idx)
              & ~own_l[l_idx] & ~own_r[l_idx];
  end

  // R3
  excl_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  // R10
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_wgo || r_wgo) |=> ($stable(own_l) && $stable(own_r)));

  // R8
  tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tie_req |=> own_l[$past(l_idx)]);

  // R9
  l_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rgo |=> l_rdata == {DATA_W{$past(l_view)}});

  // R9
  r_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r_rgo |=> r_rdata == {DATA_W{$past(r_view)}});

  // R9
  l_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rgo |=> $stable(l_rdata));

  // R9
  r_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rgo |=> $stable(r_rdata));
endmodule

bind sem_bank sem_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
  .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
  .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_test.sv
`timescale 1ns/1ps
module sem_bank_test;
  localparam int AW = 14;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          l_sel, l_mem_en, l_wr, l_rd;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wdata, l_rdata;
  logic          r_sel, r_mem_en, r_wr, r_rd;
  logic [AW-1:0] r_addr;
  logic [DW-1:0] r_wdata, r_rdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  kctr   = 0;
  bit  done   = 1'b0;

  always #4 clk = ~clk;

  sem_bank #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_sel(l_sel), .l_mem_en(l_mem_en), .l_wr(l_wr), .l_rd(l_rd),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_mem_en(r_mem_en), .r_wr(r_wr), .r_rd(r_rd),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  function automatic logic [AW-1:0] ad(input int s);
    kctr++;
    return AW'((((kctr * 37) & 2047) << 3) | (s & 7));
  endfunction

  task automatic vchk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    l_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0;
    r_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0;
  endtask

  task automatic set_l(input int s, input bit wr, input logic [DW-1:0] d, input bit sel, input bit me);
    l_sel = sel; l_mem_en = me; l_wr = wr; l_rd = ~wr; l_addr = ad(s); l_wdata = d;
  endtask

  task automatic set_r(input int s, input bit wr, input logic [DW-1:0] d, input bit sel, input bit me);
    r_sel = sel; r_mem_en = me; r_wr = wr; r_rd = ~wr; r_addr = ad(s); r_wdata = d;
  endtask

  task automatic wl(input int s, input logic [DW-1:0] d);
    set_l(s, 1, d, 1, 0); step();
  endtask

  task automatic wr_r(input int s, input logic [DW-1:0] d);
    set_r(s, 1, d, 1, 0); step();
  endtask

  task automatic cl(input int s, input bit e, input string tag);
    set_l(s, 0, '0, 1, 0); step();
    vchk({"left ", tag}, l_rdata, {DW{e}});
  endtask

  task automatic cr(input int s, input bit e, input string tag);
    set_r(s, 0, '0, 1, 0); step();
    vchk({"right ", tag}, r_rdata, {DW{e}});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    l_sel = 0; l_mem_en = 0; l_wr = 0; l_rd = 0; l_addr = '0; l_wdata = '0;
    r_sel = 0; r_mem_en = 0; r_wr = 0; r_rd = 0; r_addr = '0; r_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    vchk("R1 left reset rdata", l_rdata, '1);
    vchk("R1 right reset rdata", r_rdata, '1);

    for (int s = 0; s < 8; s++) begin
      int o;
      o = (s + 1) % 8;
      cl(s, 1, "R1 free"); cr(s, 1, "R1 free");
      // R3 / R4: request with upper data bits set, bit 0 clear
      wl(s, 16'hFFFE);
      cl(s, 0, "R3 owner"); cr(s, 1, "R3 other"); // R2 varying upper address bits
      cl(o, 1, "R11 neighbour"); cr(o, 1, "R11 neighbour");
      // R10: blocked release attempts
      set_l(s, 1, 16'h0001, 1, 1); step();
      set_l(s, 1, 16'h0001, 0, 0); step();
      cl(s, 0, "R10 blocked write");
      // R6: pending takeover
      wr_r(s, 16'h0000);
      cr(s, 1, "R6 pending"); cl(s, 0, "R6 holder");
      wl(s, 16'h0001);
      cr(s, 0, "R6 takeover"); cl(s, 1, "R6 released");
      // R9: hold across a change caused by the other side
      wl(s, 16'h5554);
      cl(s, 1, "R9 pre");
      wr_r(s, 16'hFFFF);
      @(negedge clk);
      vchk("left R9 hold", l_rdata, '1);
      cl(s, 0, "R6 left takeover"); cr(s, 1, "R6 right lost");
      // R7: cancel then free
      wr_r(s, 16'h0000);
      wr_r(s, 16'h0003);
      cr(s, 1, "R7 cancel");
      wl(s, 16'hFFFF);
      cl(s, 1, "R5 free"); cr(s, 1, "R7 free after cancel");
      // R8: simultaneous request
      set_l(s, 1, 16'h8000, 1, 0); set_r(s, 1, 16'h00F0, 1, 0); step();
      cl(s, 0, "R8 left wins"); cr(s, 1, "R8 right waits");
      wl(s, 16'h0001);
      cr(s, 0, "R8 pending right takes over");
      wr_r(s, 16'h0001);
      cl(s, 1, "R5 both free"); cr(s, 1, "R5 both free");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule